// File: doc/BRIEF.md
# Triggered SAR Conversion Sequencer

This block is the digital controller of a successive-approximation converter. A programmable divider turns the system clock into a slower conversion clock, and the controller places all conversion events on that clock's edges. A conversion starts when software writes the start bit. It also starts when the chosen external trigger source produces a rising edge while auto-triggering is on. The block then produces a one-cycle sample-and-hold strobe at a half-period point. It resolves ten result bits, most significant bit first, by presenting trial codes to the DAC and reading back the comparator bit. It then writes the result and raises a sticky completion flag.

The first conversion after the block is enabled gets a long initialisation lead, and every later conversion uses the short timing. An accepted trigger moves the divider to a fixed phase, so the delay from a trigger edge to its sample point is always the same whatever the divider was doing. The comparator is an external digital input.

States: `ST_IDLE` waits for the start bit or an accepted trigger. `ST_ALIGN` waits for the next conversion-clock rise, which is the start of the conversion. `ST_ACQ` counts conversion-clock rises up to the hold point and fires the strobe on the falling tick there. `ST_RESOLVE` loads the first trial code and then takes one comparator decision per rise. `ST_FINISH` writes the result on the following rise and returns to `ST_IDLE`. Transitions: IDLE→ALIGN on the start bit or an accepted trigger; ALIGN→ACQ on a rise; ACQ→RESOLVE on the hold falling tick; RESOLVE→FINISH on the decision for the last bit; FINISH→IDLE on a rise; any state→IDLE while the enable is low.

Top module: `sar_conv_seq`

## Requirements
- R1: The conversion-clock period P in system clocks is 2 for `div_sel` 0 and 1, and 2^`div_sel` for `div_sel` 2 to 7, so the largest divider is 128.
- R2: In a normal conversion the result is written 13 conversion clocks after the start. With auto-triggering this is 13.5·P+3 system-clock edges after the first edge that samples the trigger high. The finish comes 11.5·P edges after the sample strobe.
- R3: The first conversion after reset or after `conv_en` rises lasts 25 conversion clocks, with hold at 13.5 clocks after the start. With auto-triggering the strobe comes 14·P+3 edges after the first edge that samples the trigger high, and the finish 25.5·P+3 edges after it.
- R4: For a normal auto-triggered conversion, `sample_hold` rises 2·P+3 edges after the first edge that samples the trigger high. This holds for every divider phase at the trigger, because an accepted trigger moves the divider to its midpoint.
- R5: A trigger is accepted only when `auto_en` is 1, and only from the source `trig_src[trig_pick]`. Edges on the other sources, or on any source while `auto_en` is 0, start nothing.
- R6: A `start_set` pulse makes `start_busy` read 1 from the next cycle. The conversion starts on the next conversion-clock rise. `sample_hold` is one system clock wide.
- R7: The result has 10 bits and is resolved MSB first. Each trial bit is kept when `cmp_in` is 1 and cleared when it is 0. With `cmp_in` = (input ≥ `dac_code`), the result equals the 10-bit input.
- R8: At the finish, `result` takes the new code, `done_flag` is 1 and `start_busy` drops to 0, all on the same edge.
- R9: `done_flag` stays set until a `flag_clr` pulse. If a finish and a clear fall in the same cycle, the flag stays set.
- R10: `irq` is 1 exactly when `done_flag` and `irq_en` are both 1.
- R11: A trigger edge that arrives while `start_busy` is 1 is ignored: no second strobe and no second result.
- R12: While `conv_en` is 0, a running conversion is dropped, `start_busy` reads 0, and the next conversion uses first-conversion timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_en | input | 1 | Converter enable |
| start_set | input | 1 | Software write of 1 to the start bit (pulse) |
| auto_en | input | 1 | Auto-trigger enable |
| trig_pick | input | 2 | Trigger source select |
| trig_src | input | 4 | External trigger sources (one may be a timer overflow) |
| div_sel | input | 3 | Conversion-clock divider select |
| flag_clr | input | 1 | Write-one-to-clear pulse for the completion flag |
| irq_en | input | 1 | Interrupt enable |
| cmp_in | input | 1 | Comparator decision bit |
| sample_hold | output | 1 | Sample-and-hold strobe, one system clock |
| dac_code | output | 10 | Trial code presented to the DAC |
| result | output | 10 | Data register |
| start_busy | output | 1 | Start bit, high while a conversion is pending or running |
| done_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt request |

## Verification
Each auto-triggered conversion is timed from the first clock edge that can see the trigger high. The strobe is due 2·P+3 edges later, or 14·P+3 for a first conversion. The finish, seen as the fall of the start bit, is due 13.5·P+3 edges later, or 25.5·P+3. Software starts have an unknown divider phase, so only the finish is timed, at 11.5·P edges after the observed strobe. The driver records the edge count at the trigger and queues the due cycles. The monitor samples on falling clock edges and compares each event's cycle and result against the next queued item. An event with nothing queued is a failure, and this is how ignored triggers are caught.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;

    // Control states of the conversion sequencer
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ALIGN   = 3'd1,
        ST_ACQ     = 3'd2,
        ST_RESOLVE = 3'd3,
        ST_FINISH  = 3'd4
    } seq_state_t;

endpackage

// File: rtl/sar_clk_div.sv
`timescale 1ns/1ps
// Conversion-clock divider: emits a rising tick at the end of each period
// and a falling tick at the period midpoint. Resync moves the phase to the midpoint.
module sar_clk_div #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             resync,
    input  logic [SEL_W-1:0] sel,
    output logic             rise_tk,
    output logic             fall_tk
);
    localparam int CNT_W = (1 << SEL_W) - 1;
    localparam logic [CNT_W:0]   P_ONE   = (CNT_W+1)'(1);
    localparam logic [CNT_W:0]   P_TWO   = (CNT_W+1)'(2);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   period;
    logic [CNT_W:0]   half;

    always_comb begin
        if (sel == '0) period = P_TWO;
        else           period = P_ONE << sel;
        half = period >> 1;
    end

    assign rise_tk = ({1'b0, cnt} >= (period - P_ONE));
    assign fall_tk = ({1'b0, cnt} == (half - P_ONE));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (!run)    cnt <= '0;
        else if (resync)  cnt <= half[CNT_W-1:0];
        else if (rise_tk) cnt <= '0;
        else              cnt <= cnt + CNT_ONE;
    end

endmodule

// File: rtl/sar_trig_sync.sv
`timescale 1ns/1ps
// Trigger source select, synchronizer chain and rising-edge detector.
module sar_trig_sync #(
    parameter int N_SRC  = 4,
    parameter int STAGES = 3,
    parameter int PICK_W = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src,
    input  logic [PICK_W-1:0] pick,
    output logic              edge_ev
);
    logic              picked;
    logic [STAGES-1:0] chain;
    logic              last_q;

    assign picked = src[pick];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain  <= '0;
            last_q <= 1'b0;
        end else begin
            for (int i = STAGES - 1; i > 0; i--) chain[i] <= chain[i-1];
            chain[0] <= picked;
            last_q   <= chain[STAGES-1];
        end
    end

    assign edge_ev = chain[STAGES-1] & ~last_q;

endmodule

// File: rtl/sar_shift_reg.sv
`timescale 1ns/1ps
// Successive-approximation register with a one-hot trial pointer.
module sar_shift_reg #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic         step,
    input  logic         cmp,
    output logic [W-1:0] code,
    output logic         active,
    output logic         last
);
    localparam logic [W-1:0] MSB_ONLY = W'(1) << (W - 1);

    logic [W-1:0] code_q;
    logic [W-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            ptr_q  <= '0;
        end else if (clr) begin
            ptr_q  <= '0;
        end else if (load) begin
            code_q <= MSB_ONLY;
            ptr_q  <= MSB_ONLY;
        end else if (step) begin
            // keep or drop the current trial bit, then set the next one
            code_q <= (cmp ? code_q : (code_q & ~ptr_q)) | (ptr_q >> 1);
            ptr_q  <= ptr_q >> 1;
        end
    end

    assign code   = code_q;
    assign active = |ptr_q;
    assign last   = ptr_q[0];

endmodule

// File: rtl/sar_conv_seq.sv
`timescale 1ns/1ps
module sar_conv_seq
    import sar_seq_pkg::*;
#(
    parameter int RES_W       = 10,
    parameter int DIV_SEL_W   = 3,
    parameter int TRIG_N      = 4,
    parameter int SYNC_STAGES = 3,
    parameter int NORM_HOLD   = 1,
    parameter int FIRST_HOLD  = 13,
    parameter int TSEL_W      = $clog2(TRIG_N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 conv_en,
    input  logic                 start_set,
    input  logic                 auto_en,
    input  logic [TSEL_W-1:0]    trig_pick,
    input  logic [TRIG_N-1:0]    trig_src,
    input  logic [DIV_SEL_W-1:0] div_sel,
    input  logic                 flag_clr,
    input  logic                 irq_en,
    input  logic                 cmp_in,
    output logic                 sample_hold,
    output logic [RES_W-1:0]     dac_code,
    output logic [RES_W-1:0]     result,
    output logic                 start_busy,
    output logic                 done_flag,
    output logic                 irq
);
    localparam int STEP_W = $clog2(FIRST_HOLD + 1);
    localparam logic [STEP_W-1:0] HOLD_N = STEP_W'(NORM_HOLD);
    localparam logic [STEP_W-1:0] HOLD_F = STEP_W'(FIRST_HOLD);
    localparam logic [STEP_W-1:0] STEP_1 = STEP_W'(1);

    seq_state_t st, st_nxt;

    logic rise_tk, fall_tk, trig_ev;
    logic div_resync, accept_trig, sar_load, sar_step, hold_now, finish;
    logic sar_active, sar_last;
    logic [RES_W-1:0] sar_code;

    logic              sc_bit, flag_q, first_pend, sample_q;
    logic [RES_W-1:0]  result_q;
    logic [STEP_W-1:0] step_cnt;
    logic [STEP_W-1:0] hold_pt;

    assign hold_pt = first_pend ? HOLD_F : HOLD_N;

    sar_clk_div #(.SEL_W(DIV_SEL_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (conv_en),
        .resync  (div_resync),
        .sel     (div_sel),
        .rise_tk (rise_tk),
        .fall_tk (fall_tk)
    );

    sar_trig_sync #(.N_SRC(TRIG_N), .STAGES(SYNC_STAGES), .PICK_W(TSEL_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (trig_src),
        .pick    (trig_pick),
        .edge_ev (trig_ev)
    );

    sar_shift_reg #(.W(RES_W)) u_sar (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!conv_en),
        .load   (sar_load),
        .step   (sar_step),
        .cmp    (cmp_in),
        .code   (sar_code),
        .active (sar_active),
        .last   (sar_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // Next state and per-cycle strobes
    always_comb begin
        st_nxt      = st;
        div_resync  = 1'b0;
        accept_trig = 1'b0;
        sar_load    = 1'b0;
        sar_step    = 1'b0;
        hold_now    = 1'b0;
        finish      = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (sc_bit) begin
                    st_nxt = ST_ALIGN;
                end else if (auto_en && trig_ev) begin
                    st_nxt      = ST_ALIGN;
                    div_resync  = 1'b1;
                    accept_trig = 1'b1;
                end
            end
            ST_ALIGN: begin
                if (rise_tk) st_nxt = ST_ACQ;
            end
            ST_ACQ: begin
                if (fall_tk && (step_cnt == hold_pt)) begin
                    hold_now = 1'b1;
                    st_nxt   = ST_RESOLVE;
                end
            end
            ST_RESOLVE: begin
                if (rise_tk) begin
                    if (!sar_active) begin
                        sar_load = 1'b1;
                    end else begin
                        sar_step = 1'b1;
                        if (sar_last) st_nxt = ST_FINISH;
                    end
                end
            end
            ST_FINISH: begin
                if (rise_tk) begin
                    finish = 1'b1;
                    st_nxt = ST_IDLE;
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
        if (!conv_en) begin
            st_nxt      = ST_IDLE;
            div_resync  = 1'b0;
            accept_trig = 1'b0;
            sar_load    = 1'b0;
            sar_step    = 1'b0;
            hold_now    = 1'b0;
            finish      = 1'b0;
        end
    end

    // Registered outputs and control bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sc_bit     <= 1'b0;
            flag_q     <= 1'b0;
            first_pend <= 1'b1;
            sample_q   <= 1'b0;
            result_q   <= '0;
            step_cnt   <= '0;
        end else begin
            sample_q <= hold_now;

            if (!conv_en)                      sc_bit <= 1'b0;
            else if (finish)                   sc_bit <= 1'b0;
            else if (start_set || accept_trig) sc_bit <= 1'b1;

            if (finish)        flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;

            if (finish) result_q <= sar_code;

            if (!conv_en)    first_pend <= 1'b1;
            else if (finish) first_pend <= 1'b0;

            if (st == ST_ALIGN && rise_tk)   step_cnt <= '0;
            else if (st == ST_ACQ && rise_tk) step_cnt <= step_cnt + STEP_1;
        end
    end

    assign sample_hold = sample_q;
    assign dac_code    = sar_code;
    assign result      = result_q;
    assign start_busy  = sc_bit;
    assign done_flag   = flag_q;
    assign irq         = flag_q & irq_en;

endmodule

// File: rtl/sar_conv_seq_chk.sv
`timescale 1ns/1ps
module sar_conv_seq_chk #(
    parameter int RES_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             conv_en,
    input logic             flag_clr,
    input logic             sample_hold,
    input logic             start_busy,
    input logic             done_flag,
    input logic [RES_W-1:0] result
);

    a_r8_flag_with_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $fell(start_busy));

    a_r8_result_only_at_finish: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> $fell(start_busy));

    a_r6_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        sample_hold |=> !sample_hold);

    a_r11_strobe_inside_conv: assert property (@(posedge clk) disable iff (!rst_n)
        sample_hold |-> start_busy);

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !flag_clr) |=> done_flag);

    a_r12_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_en |=> !start_busy);

endmodule

bind sar_conv_seq sar_conv_seq_chk #(.RES_W(RES_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_en     (conv_en),
    .flag_clr    (flag_clr),
    .sample_hold (sample_hold),
    .start_busy  (start_busy),
    .done_flag   (done_flag),
    .result      (result)
);

// File: tb/sar_conv_seq_test.sv
`timescale 1ns/1ps
module sar_conv_seq_test;
    localparam int RW = 10;

    logic clk = 1'b0, rst_n = 1'b0, conv_en = 1'b0, start_set = 1'b0;
    logic auto_en = 1'b0, flag_clr = 1'b0, irq_en = 1'b0;
    logic [1:0] trig_pick = 2'd2;
    logic [3:0] trig_src = 4'd0;
    logic [2:0] div_sel = 3'd1;
    logic [RW-1:0] vin = '0;
    wire cmp_in;
    wire sample_hold, start_busy, done_flag, irq;
    wire [RW-1:0] dac_code, result;

    assign cmp_in = (vin >= dac_code);
    always #10 clk = ~clk;

    sar_conv_seq uut (
        .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .start_set(start_set),
        .auto_en(auto_en), .trig_pick(trig_pick), .trig_src(trig_src),
        .div_sel(div_sel), .flag_clr(flag_clr), .irq_en(irq_en), .cmp_in(cmp_in),
        .sample_hold(sample_hold), .dac_code(dac_code), .result(result),
        .start_busy(start_busy), .done_flag(done_flag), .irq(irq)
    );

    typedef struct {
        bit    is_done;
        bit    rel;
        int    at;
        int    val;
        string req;
    } exp_t;
    exp_t expq[$];

    int total = 0, bad = 0, cyc = 0, last_samp = 0, n_samp = 0;
    bit ignore_fall = 1'b0;
    logic prev_s = 1'b0, prev_b = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    function automatic int per();
        return (div_sel == 3'd0) ? 2 : (1 << div_sel);
    endfunction

    // Monitor: pops the scoreboard on each strobe and each finish
    task automatic take(input bit is_done);
        exp_t e;
        if (expq.size() == 0) begin
            chk("R11 unexpected conversion event", 1, 0);
            return;
        end
        e = expq.pop_front();
        chk({e.req, " event kind"}, int'(is_done), int'(e.is_done));
        if (e.at >= 0) chk({e.req, " event cycle"}, cyc, e.rel ? last_samp + e.at : e.at);
        if (!is_done) last_samp = cyc;
        else begin
            chk({e.req, " R7 result"}, int'(result), e.val);
            chk("R8 flag set at finish", int'(done_flag), 1);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (sample_hold && !prev_s) begin
                n_samp++;
                take(1'b0);
            end
            if (!start_busy && prev_b && !ignore_fall) take(1'b1);
        end
        prev_s = sample_hold;
        prev_b = start_busy;
    end

    // Driver tasks
    task automatic trig_conv(input int v, input bit first, input string req, output int c_out);
        int p, c;
        p = per();
        @(posedge clk); #1;
        vin = RW'(v);
        trig_src[trig_pick] = 1'b1;
        c = cyc;
        c_out = c;
        expq.push_back('{is_done: 1'b0, rel: 1'b0,
                         at: first ? c + 4 + 14*p : c + 4 + 2*p, val: 0, req: req});
        expq.push_back('{is_done: 1'b1, rel: 1'b0,
                         at: first ? c + 4 + 25*p + p/2 : c + 4 + 13*p + p/2, val: v, req: req});
        repeat (2) @(posedge clk);
        #1 trig_src = '0;
    endtask

    task automatic sw_conv(input int v, input string req);
        int p;
        p = per();
        @(posedge clk); #1;
        vin = RW'(v);
        start_set = 1'b1;
        expq.push_back('{is_done: 1'b0, rel: 1'b0, at: -1, val: 0, req: req});
        expq.push_back('{is_done: 1'b1, rel: 1'b1, at: 11*p + p/2, val: v, req: req});
        @(posedge clk); #1 start_set = 1'b0;
        chk("R6 start bit reads 1 after write", int'(start_busy), 1);
    endtask

    task automatic drain();
        while (expq.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic clear_flag();
        @(posedge clk); #1 flag_clr = 1'b1;
        @(posedge clk); #1 flag_clr = 1'b0;
    endtask

    task automatic pulse_src(input int idx);
        @(posedge clk); #1 trig_src[idx] = 1'b1;
        repeat (2) @(posedge clk);
        #1 trig_src = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int c, d, ns;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R9 reset flag", int'(done_flag), 0);
        chk("R10 reset irq", int'(irq), 0);
        chk("R6 reset start bit", int'(start_busy), 0);
        chk("R7 reset result", int'(result), 0);

        conv_en = 1'b1;
        auto_en = 1'b1;
        trig_pick = 2'd2;
        div_sel = 3'd1;

        // R3 first conversion, P=2
        trig_conv(10'h2A5, 1'b1, "R3 first conv", c);
        drain();
        repeat (10) @(posedge clk);
        #1 chk("R9 flag held", int'(done_flag), 1);
        chk("R10 irq off when disabled", int'(irq), 0);
        irq_en = 1'b1;
        #1 chk("R10 irq follows flag", int'(irq), 1);
        clear_flag();
        chk("R9 flag cleared", int'(done_flag), 0);
        chk("R10 irq drops", int'(irq), 0);

        // R4 normal conversion fixed delay, P=2
        trig_conv(10'h3FF, 1'b0, "R4 normal P2", c);
        drain(); clear_flag();

        // R1 / R4 with P=16 at two divider phases
        div_sel = 3'd4;
        repeat (7) @(posedge clk);
        trig_conv(10'h155, 1'b0, "R1 P16", c);
        drain(); clear_flag();
        repeat (23) @(posedge clk);
        trig_conv(10'h000, 1'b0, "R2 P16 phase", c);
        drain(); clear_flag();

        // R1 largest divider
        div_sel = 3'd7;
        trig_conv(10'h200, 1'b0, "R1 P128", c);
        drain(); clear_flag();

        // R5 gating and source select
        div_sel = 3'd2;
        ns = n_samp;
        auto_en = 1'b0;
        pulse_src(2);
        repeat (200) @(posedge clk);
        #1 chk("R5 no start with auto off", n_samp - ns, 0);
        chk("R5 start bit idle", int'(start_busy), 0);
        auto_en = 1'b1;
        pulse_src(1);
        repeat (200) @(posedge clk);
        #1 chk("R5 unselected source ignored", n_samp - ns, 0);
        trig_pick = 2'd1;
        trig_conv(10'h0C3, 1'b0, "R5 selected source", c);
        drain(); clear_flag();

        // R11 retrigger while busy
        ns = n_samp;
        trig_conv(10'h111, 1'b0, "R11 busy", c);
        repeat (10 * per()) @(posedge clk);
        pulse_src(1);
        drain();
        repeat (40 * per()) @(posedge clk);
        #1 chk("R11 single strobe", n_samp - ns, 1);
        clear_flag();

        // R6 / R7 software start
        auto_en = 1'b0;
        sw_conv(10'h0F0, "R6 sw start");
        drain();
        chk("R8 start bit cleared", int'(start_busy), 0);
        clear_flag();
        sw_conv(10'h301, "R7 sw start");
        drain(); clear_flag();

        // R9 set wins over clear
        auto_en = 1'b1;
        trig_conv(10'h050, 1'b0, "R9 pre", c);
        drain();
        trig_conv(10'h3A0, 1'b0, "R9 set-wins", c);
        d = c + 4 + 13*per() + per()/2;
        while (cyc != d - 1) begin @(posedge clk); #1; end
        flag_clr = 1'b1;
        @(posedge clk); #1 flag_clr = 1'b0;
        drain();
        chk("R9 set wins over clear", int'(done_flag), 1);
        clear_flag();

        // R12 abort by disable, then first timing again
        div_sel = 3'd4;
        ns = n_samp;
        pulse_src(1);
        repeat (6) @(posedge clk);
        #1 ignore_fall = 1'b1;
        conv_en = 1'b0;
        @(posedge clk); #1;
        chk("R12 start bit dropped", int'(start_busy), 0);
        chk("R12 no strobe", n_samp - ns, 0);
        repeat (5) @(posedge clk);
        #1 conv_en = 1'b1;
        @(posedge clk); #1 ignore_fall = 1'b0;
        trig_conv(10'h2EE, 1'b1, "R12 first after enable", c);
        drain(); clear_flag();
        chk("R12 flag cleared", int'(done_flag), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule